// File: doc/BRIEF.md
# Command-Memory AXI4-Lite Write Player

This block replays a short configuration program held in an internal command array. Each 40-bit entry is decoded in turn. An entry can latch a target address, issue one AXI4-Lite write of its operand to that address, or hold the player idle for a counted number of clock cycles. With it, a peripheral behind an AXI4-Lite slave port can be reconfigured at run time without a processor.

A typical program does three things. It writes 1 to a start register at address 0. It then writes packed configuration words to address 4. Between those writes it pauses long enough for the effect to be heard or measured; at a 125 MHz clock, 375,000,000 cycles is three seconds.

The program ends at an all-zero entry, or at the last array entry. The player then raises a sticky done flag and stays quiet until the next reset. The array is a plain internal variable that is cleared at start-up and loaded from outside, for example by a bench, while reset is held.

Top module: `axil_cmd_player`

## Requirements
- R1: An entry holds an opcode in bits [7:0] and a 32-bit operand in bits [39:8]. Entries run in index order from entry 0, and each entry that is not a write or a pause spends exactly one clock cycle being decoded.
- R2: Opcode 0x01 loads the operand as the write address. The address stays in force for every later write until the next 0x01 entry. After reset the address is 0.
- R3: Opcode 0x0F makes exactly one write of the operand to the current address, with all four strobe bits (0xF) set. AWVALID and WVALID rise in the same cycle. Each is held, with its payload stable, until its own READY is seen, and the two handshakes may complete in either order.
- R4: BREADY rises only after both the address and the data handshake have completed, and it stays high until BVALID is seen. The entry after a write is decoded in the cycle after the response handshake, so back-to-back writes put two cycles between that handshake and the next AWVALID.
- R5: Opcode 0x07 with operand N keeps the player idle for N cycles more than a one-cycle entry takes. An operand of 0 adds no delay.
- R6: An entry that is all zeros stops the sequence and raises done.
- R7: If the last array entry (index DEPTH-1) is executed without meeting an all-zero entry, the player stops and raises done once that entry has finished.
- R8: While reset is low, AWVALID, WVALID, BREADY and done are low. After reset the program restarts from entry 0.
- R9: An entry with any other opcode and a nonzero word is skipped. It issues no write and takes one cycle, like an address entry.
- R10: Once done is high it stays high until reset, and no further AXI4-Lite traffic is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_awaddr | output | 32 | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready from slave |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes, all set on every write |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready from slave |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Write response ready |
| done | output | 1 | Sticky end-of-program flag |

## Verification
The assertions assume the slave follows AXI4-Lite ordering. It never asserts BVALID before both the address and data handshakes have completed, and it keeps BVALID high until BREADY takes it. The bench's slave model keeps to this. It raises each READY only while the matching VALID is high, after a programmable wait. It drives BVALID one cycle after both handshakes are logged and drops it on the handshake. This lets the hold and ordering properties be judged against legal responses only, while the waits are varied so that address-first and data-first completion both occur.

// File: rtl/axil_cmd_player.sv
module axil_cmd_player #(
  parameter int DEPTH = 16,
  parameter int OP_W  = 8,
  parameter int ARG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [ARG_W-1:0]   m_awaddr,
  output logic               m_awvalid,
  input  logic               m_awready,
  output logic [ARG_W-1:0]   m_wdata,
  output logic [ARG_W/8-1:0] m_wstrb,
  output logic               m_wvalid,
  input  logic               m_wready,
  input  logic               m_bvalid,
  output logic               m_bready,
  output logic               done
);
  localparam int CMD_W = OP_W + ARG_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [OP_W-1:0] OP_ADDR  = OP_W'(8'h01);
  localparam logic [OP_W-1:0] OP_WRITE = OP_W'(8'h0F);
  localparam logic [OP_W-1:0] OP_SLEEP = OP_W'(8'h07);

  typedef enum logic [2:0] {S_EXEC, S_WR, S_RESP, S_SLEEP, S_STOP} state_t;

  logic [CMD_W-1:0] prog_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) prog_mem[i] = '0;
  end

  state_t            st;
  logic [PTR_W-1:0]  ptr;
  logic [ARG_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd;
  logic [OP_W-1:0]   op;
  logic [ARG_W-1:0]  arg;
  logic              last, adv, aw_fin, w_fin;

  assign cmd     = prog_mem[ptr];
  assign op      = cmd[OP_W-1:0];
  assign arg     = cmd[CMD_W-1:OP_W];
  assign last    = (ptr == PTR_W'(DEPTH - 1));
  assign m_wstrb = '1;
  assign aw_fin  = !m_awvalid || m_awready;
  assign w_fin   = !m_wvalid  || m_wready;

  assign adv = (st == S_EXEC && cmd != '0 && op != OP_WRITE &&
                !(op == OP_SLEEP && arg != '0))
             || (st == S_RESP  && m_bvalid)
             || (st == S_SLEEP && cnt == ARG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_EXEC;
      ptr       <= '0;
      cnt       <= '0;
      m_awaddr  <= '0;
      m_wdata   <= '0;
      m_awvalid <= 1'b0;
      m_wvalid  <= 1'b0;
      m_bready  <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (st)
        S_EXEC: begin
          if (cmd == '0) begin
            st   <= S_STOP;
            done <= 1'b1;
          end else if (op == OP_ADDR) begin
            m_awaddr <= arg;
          end else if (op == OP_WRITE) begin
            m_wdata   <= arg;
            m_awvalid <= 1'b1;
            m_wvalid  <= 1'b1;
            st        <= S_WR;
          end else if (op == OP_SLEEP && arg != '0) begin
            cnt <= arg;
            st  <= S_SLEEP;
          end
        end
        S_WR: begin
          if (m_awvalid && m_awready) m_awvalid <= 1'b0;
          if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
          if (aw_fin && w_fin) begin
            m_bready <= 1'b1;
            st       <= S_RESP;
          end
        end
        S_RESP:  if (m_bvalid) m_bready <= 1'b0;
        S_SLEEP: cnt <= cnt - ARG_W'(1);
        default: ;
      endcase
      if (adv) begin
        if (last) begin
          st   <= S_STOP;
          done <= 1'b1;
        end else begin
          ptr <= ptr + PTR_W'(1);
          st  <= S_EXEC;
        end
      end
    end
  end
endmodule

// File: rtl/axil_cmd_player_chk.sv
module axil_cmd_player_chk #(
  parameter int ARG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ARG_W-1:0] m_awaddr,
  input logic             m_awvalid,
  input logic             m_awready,
  input logic [ARG_W-1:0] m_wdata,
  input logic             m_wvalid,
  input logic             m_wready,
  input logic             m_bvalid,
  input logic             m_bready,
  input logic             done
);
  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

  assert_w_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));

  assert_pair_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid) |-> $rose(m_wvalid));

  assert_bready_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_bready |-> !m_awvalid && !m_wvalid);

  assert_bready_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_bready && !m_bvalid |=> m_bready);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_awvalid && !m_wvalid && !m_bready);
endmodule

bind axil_cmd_player axil_cmd_player_chk #(.ARG_W(ARG_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wdata(m_wdata), .m_wvalid(m_wvalid), .m_wready(m_wready),
  .m_bvalid(m_bvalid), .m_bready(m_bready), .done(done)
);

// File: tb/axil_cmd_player_tb_top.sv
`timescale 1ns/1ps
module axil_cmd_player_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] awaddr, wdata;
  logic [3:0]  wstrb;
  logic awvalid, wvalid, bready, done;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;

  axil_cmd_player #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .m_awaddr(awaddr), .m_awvalid(awvalid), .m_awready(awready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wvalid(wvalid), .m_wready(wready),
    .m_bvalid(bvalid), .m_bready(bready), .done(done)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int aw_dly = 0, w_dly = 0;
  int aw_wait = 0, w_wait = 0;
  logic aw_got = 1'b0, w_got = 1'b0, aw_seen = 1'b0;
  int nw = 0, viol4 = 0;
  logic [31:0] log_addr [32];
  logic [31:0] log_data [32];
  logic [3:0]  log_strb [32];
  int b_cyc [32];
  int aw_cyc [32];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      awready <= 1'b0; wready <= 1'b0; bvalid <= 1'b0;
      aw_got <= 1'b0; w_got <= 1'b0; aw_seen <= 1'b0;
      aw_wait <= 0; w_wait <= 0; nw <= 0;
    end else begin
      if (bready && !(aw_got && w_got)) viol4 <= viol4 + 1;
      if (awvalid && !aw_seen && nw < 32) begin aw_cyc[nw] <= cyc; aw_seen <= 1'b1; end
      if (awvalid && !aw_got) begin
        if (awready) begin
          aw_got <= 1'b1; awready <= 1'b0;
          if (nw < 32) log_addr[nw] <= awaddr;
        end else if (aw_wait >= aw_dly) awready <= 1'b1;
        else aw_wait <= aw_wait + 1;
      end
      if (wvalid && !w_got) begin
        if (wready) begin
          w_got <= 1'b1; wready <= 1'b0;
          if (nw < 32) begin log_data[nw] <= wdata; log_strb[nw] <= wstrb; end
        end else if (w_wait >= w_dly) wready <= 1'b1;
        else w_wait <= w_wait + 1;
      end
      if (aw_got && w_got && !bvalid) bvalid <= 1'b1;
      if (bvalid && bready) begin
        bvalid <= 1'b0; aw_got <= 1'b0; w_got <= 1'b0; aw_seen <= 1'b0;
        aw_wait <= 0; w_wait <= 0;
        if (nw < 32) b_cyc[nw] <= cyc;
        nw <= nw + 1;
      end
    end
  end

  function automatic logic [39:0] c_addr(input logic [31:0] a); return {a, 8'h01}; endfunction
  function automatic logic [39:0] c_wr(input logic [31:0] d);   return {d, 8'h0F}; endfunction
  function automatic logic [39:0] c_sl(input logic [31:0] n);   return {n, 8'h07}; endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input int ad, input int wd);
    @(negedge clk);
    rst_n = 1'b0;
    aw_dly = ad; w_dly = wd;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) dut_i.prog_mem[i] = '0;
  endtask

  task automatic go();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, req, done, 1);
  endtask

  task automatic t_reset();
    start(0, 0);
    dut_i.prog_mem[0] = c_wr(32'h1234);
    @(negedge clk);
    chk(!awvalid && !wvalid && !bready && !done, "R8 reset outputs",
        {awvalid, wvalid, bready, done}, 0);
  endtask

  task automatic t_basic();
    start(0, 0);
    dut_i.prog_mem[0] = c_addr(32'h0);
    dut_i.prog_mem[1] = c_wr(32'h1);
    dut_i.prog_mem[2] = c_addr(32'h4);
    dut_i.prog_mem[3] = c_wr(32'h06102010);
    dut_i.prog_mem[4] = c_sl(32'd5);
    dut_i.prog_mem[5] = c_wr(32'h06F020F0);
    go();
    wait_done("R6 end word");
    chk(nw == 3, "R6 write count", nw, 3);
    chk(log_addr[0] == 32'h0 && log_data[0] == 32'h1, "R1 first write",
        {log_addr[0], log_data[0]}, 64'h1);
    chk(log_addr[1] == 32'h4 && log_data[1] == 32'h06102010, "R2 address load",
        {log_addr[1], log_data[1]}, 64'h4_06102010);
    chk(log_addr[2] == 32'h4 && log_data[2] == 32'h06F020F0, "R2 address persists",
        {log_addr[2], log_data[2]}, 64'h4_06F020F0);
    chk(log_strb[0] == 4'hF && log_strb[1] == 4'hF && log_strb[2] == 4'hF, "R3 strobes",
        {log_strb[0], log_strb[1], log_strb[2]}, 12'hFFF);
    chk(aw_cyc[1] - b_cyc[0] == 3, "R1 one-cycle address entry", aw_cyc[1] - b_cyc[0], 3);
    chk(aw_cyc[2] - b_cyc[1] == 8, "R5 pause of 5", aw_cyc[2] - b_cyc[1], 8);
    repeat (20) @(negedge clk);
    chk(done && nw == 3 && !awvalid && !wvalid, "R10 quiet after done", nw, 3);
  endtask

  task automatic t_order(input int ad, input int wd, input string req);
    start(ad, wd);
    dut_i.prog_mem[0] = c_addr(32'h10);
    dut_i.prog_mem[1] = c_wr(32'hA5A50001);
    dut_i.prog_mem[2] = c_wr(32'h5A5A0002);
    go();
    wait_done(req);
    chk(nw == 2 && log_addr[0] == 32'h10 && log_data[0] == 32'hA5A50001, req,
        log_data[0], 32'hA5A50001);
    chk(log_addr[1] == 32'h10 && log_data[1] == 32'h5A5A0002, req, log_data[1], 32'h5A5A0002);
    chk(viol4 == 0, "R4 bready after both handshakes", viol4, 0);
    chk(aw_cyc[1] - b_cyc[0] == 2, "R4 back-to-back spacing", aw_cyc[1] - b_cyc[0], 2);
  endtask

  task automatic t_sleep(input int n);
    start(0, 0);
    dut_i.prog_mem[0] = c_wr(32'h11);
    dut_i.prog_mem[1] = c_sl(n);
    dut_i.prog_mem[2] = c_wr(32'h22);
    go();
    wait_done("R5 pause run");
    chk(nw == 2 && aw_cyc[1] - b_cyc[0] == n + 3, "R5 pause length",
        aw_cyc[1] - b_cyc[0], n + 3);
  endtask

  task automatic t_unknown();
    start(0, 0);
    dut_i.prog_mem[0] = c_addr(32'h8);
    dut_i.prog_mem[1] = c_wr(32'h33);
    dut_i.prog_mem[2] = {32'hDEAD, 8'h55};
    dut_i.prog_mem[3] = {32'h1, 8'h00};
    dut_i.prog_mem[4] = c_wr(32'h44);
    go();
    wait_done("R9 run");
    chk(nw == 2 && log_data[1] == 32'h44 && log_addr[1] == 32'h8, "R9 skipped entries",
        log_data[1], 32'h44);
    chk(aw_cyc[1] - b_cyc[0] == 4, "R9 one cycle each", aw_cyc[1] - b_cyc[0], 4);
  endtask

  task automatic t_eom();
    start(0, 0);
    for (int i = 0; i < DEPTH; i++) dut_i.prog_mem[i] = c_wr(32'h100 + i);
    go();
    wait_done("R7 end of array");
    chk(nw == DEPTH && log_data[DEPTH-1] == 32'h100 + DEPTH - 1, "R7 all entries run",
        nw, DEPTH);
  endtask

  task automatic t_midreset();
    start(0, 0);
    dut_i.prog_mem[0] = c_wr(32'h77);
    dut_i.prog_mem[1] = c_sl(32'd1000);
    dut_i.prog_mem[2] = c_wr(32'h88);
    go();
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!awvalid && !wvalid && !bready && !done, "R8 reset mid-run",
        {awvalid, wvalid, bready, done}, 0);
    dut_i.prog_mem[1] = c_sl(32'd3);
    go();
    wait_done("R8 restart run");
    chk(nw == 2 && log_data[0] == 32'h77 && log_data[1] == 32'h88, "R8 restart from entry 0",
        log_data[0], 32'h77);
  endtask

  logic fin = 1'b0;

  always @(posedge clk) begin
    if (cyc > 150000 && !fin) begin
      fin = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_order(4, 0, "R3 data first");
    t_order(0, 4, "R3 address first");
    t_sleep(0);
    t_sleep(20);
    t_unknown();
    t_eom();
    t_midreset();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule